// File: doc/BRIEF.md
# Prescaled Timebase Counter with Update Control

This block is a free-running up-counter used as the time reference for a peripheral. A 16-bit divider sets how many clock cycles pass between counter steps. The counter wraps to zero after it reaches a 16-bit limit. Each wrap is an overflow. An 8-bit repetition down-counter decides which overflows become update events. An update event loads the working copies of the divider, the limit and the repetition count from the values software last wrote. It also raises an update flag, which can drive an interrupt line.

Software reaches the block through a one-cycle write port and a combinational read port, both using a 3-bit word address. Through the control word, software can:
- suppress update events;
- restrict the flag to real overflows;
- stop the counter after its first update (one-shot use);
- choose whether a new limit is buffered until the next update or used at once;
- place a copy of the flag in the top bit of the counter readback, so one read returns both.

A software strobe and an external update input both restart the count and force an update.

Top module: `tbase_timer`

## Requirements
- R1: The counter and the divider advance only while control bit 0 (run) is 1. After reset every readable word is 0, except the limit, which is 0xFFFF.
- R2: With divider value P (address 5), the counter steps once every P+1 enabled cycles.
- R3: With limit A (address 6), the counter steps up to A and then wraps to 0 on the next step.
- R4: With repetition value N (address 7), only every (N+1)-th overflow is an update event. The repetition counter reloads from address 7 at each update event.
- R5: While control bit 1 (hold) is 1, no update event occurs. The working divider and limit keep their old values. The counter still wraps at the limit.
- R6: While control bit 2 (source filter) is 1, only an overflow update sets the flag. When it is 0, the software strobe and the external input set the flag as well.
- R7: While control bit 3 (one-shot) is 1, an update event clears the run bit, and the counter stays at 0.
- R8: While control bit 7 (buffered limit) is 1, a new limit takes effect only at the next update event. When bit 7 is 0, it takes effect at once.
- R9: Writing 1 to bit 0 at address 3 clears the counter and the divider count and forces an update. update_pulse is high for the one cycle that follows any update event.
- R10: The update flag (bit 0 at address 2) is set by an update. Writing 0 clears it. Writing 1 leaves it unchanged.
- R11: irq is the update flag gated by bit 0 at address 1.
- R12: While control bit 11 (flag mirror) is 1, reading address 4 returns the flag in bit 31 and the count in bits 15:0. Otherwise bit 31 reads 0.
- R13: A one-cycle pulse on ext_update behaves like the software strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read word address |
| rd_data | output | 32 | Read data (combinational) |
| ext_update | input | 1 | External update request |
| update_pulse | output | 1 | One-cycle pulse after each update event |
| irq | output | 1 | Update interrupt request |

## Verification
Errors in the internal state show up quickly at the ports:
- A wrong working divider shows within one limit period, because the count read back at a known cycle is off.
- A repetition counter that reloads or decrements wrongly shows when the flag is set one overflow early or late.
- A shadow register loaded during hold, or a limit applied without buffering, shows as a count past the old limit within a few steps.

Every scenario stops the counter before reading it. The expected value then depends only on the number of enabled cycles, which makes each check exact to the cycle.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
    localparam int CNT_W = 16;
    localparam int PSC_W = 16;
    localparam int REP_W = 8;
    localparam int AW    = 3;
    localparam int DW    = 32;

    typedef enum logic [AW-1:0] {
        A_CTRL = 3'd0,
        A_IEN  = 3'd1,
        A_STAT = 3'd2,
        A_EVT  = 3'd3,
        A_CNT  = 3'd4,
        A_PSC  = 3'd5,
        A_ARR  = 3'd6,
        A_REP  = 3'd7
    } addr_e;

    localparam int B_RUN   = 0;
    localparam int B_HOLD  = 1;
    localparam int B_FILT  = 2;
    localparam int B_SHOT  = 3;
    localparam int B_BUF   = 7;
    localparam int B_MIRR  = 11;

    typedef struct packed {
        logic mirror;
        logic buffered;
        logic oneshot;
        logic filter;
        logic hold;
        logic run;
    } ctrl_t;

    function automatic ctrl_t unpack_ctrl(input logic [DW-1:0] w);
        ctrl_t c;
        c.run      = w[B_RUN];
        c.hold     = w[B_HOLD];
        c.filter   = w[B_FILT];
        c.oneshot  = w[B_SHOT];
        c.buffered = w[B_BUF];
        c.mirror   = w[B_MIRR];
        return c;
    endfunction

    function automatic logic [DW-1:0] pack_ctrl(input ctrl_t c);
        logic [DW-1:0] w;
        w         = '0;
        w[B_RUN]  = c.run;
        w[B_HOLD] = c.hold;
        w[B_FILT] = c.filter;
        w[B_SHOT] = c.oneshot;
        w[B_BUF]  = c.buffered;
        w[B_MIRR] = c.mirror;
        return w;
    endfunction
endpackage

// File: rtl/tbase_regs.sv
module tbase_regs
    import tbase_pkg::*;
#(
    parameter int CW   = CNT_W,
    parameter int PW   = PSC_W,
    parameter int REPW = REP_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic            opm_stop,
    input  logic            flag_set,
    output ctrl_t           ctrl,
    output logic            uie,
    output logic            flag,
    output logic            sw_upd,
    output logic [PW-1:0]   psc_pre,
    output logic [CW-1:0]   arr_pre,
    output logic [REPW-1:0] rep_pre
);
    logic ctrl_wr, stat_wr;

    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
    assign stat_wr = wr_en && (wr_addr == A_STAT);
    assign sw_upd  = wr_en && (wr_addr == A_EVT) && wr_data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            uie     <= 1'b0;
            flag    <= 1'b0;
            psc_pre <= '0;
            arr_pre <= '1;
            rep_pre <= '0;
        end else begin
            if (ctrl_wr)
                ctrl <= unpack_ctrl(wr_data);
            else if (opm_stop)
                ctrl.run <= 1'b0;
            if (wr_en && wr_addr == A_IEN) uie     <= wr_data[0];
            if (wr_en && wr_addr == A_PSC) psc_pre <= wr_data[PW-1:0];
            if (wr_en && wr_addr == A_ARR) arr_pre <= wr_data[CW-1:0];
            if (wr_en && wr_addr == A_REP) rep_pre <= wr_data[REPW-1:0];
            if (flag_set)
                flag <= 1'b1;
            else if (stat_wr && !wr_data[0])
                flag <= 1'b0;
        end
    end

    // R7: a one-shot update stops the run bit unless software rewrites it
    a_r7_oneshot_stop: assert property (@(posedge clk) disable iff (rst)
        opm_stop && !ctrl_wr |=> !ctrl.run);
    // R10: an update always leaves the flag set
    a_r10_flag_set: assert property (@(posedge clk) disable iff (rst)
        flag_set |=> flag);
    // R10: the flag only moves on an update or a status write
    a_r10_flag_hold: assert property (@(posedge clk) disable iff (rst)
        !flag_set && !stat_wr |=> $stable(flag));
endmodule

// File: rtl/tbase_prescale.sv
module tbase_prescale
    import tbase_pkg::*;
#(
    parameter int PW = PSC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          clear,
    input  logic [PW-1:0] limit,
    output logic          tick
);
    logic [PW-1:0] pcnt;

    assign tick = run && !clear && (pcnt == limit);

    always_ff @(posedge clk) begin
        if (rst || clear)
            pcnt <= '0;
        else if (run)
            pcnt <= tick ? '0 : pcnt + 1'b1;
    end

    // R2: the divider count never passes the working divider value
    a_r2_bound: assert property (@(posedge clk) disable iff (rst)
        pcnt <= limit);
    // R1: the divider is frozen while stopped
    a_r1_psc_frozen: assert property (@(posedge clk) disable iff (rst)
        !run && !clear |=> $stable(pcnt));
endmodule

// File: rtl/tbase_count.sv
module tbase_count
    import tbase_pkg::*;
#(
    parameter int CW   = CNT_W,
    parameter int PW   = PSC_W,
    parameter int REPW = REP_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  ctrl_t           ctrl,
    input  logic            sw_upd,
    input  logic            ext_upd,
    input  logic [PW-1:0]   psc_pre,
    input  logic [CW-1:0]   arr_pre,
    input  logic [REPW-1:0] rep_pre,
    output logic [CW-1:0]   cnt,
    output logic [PW-1:0]   psc_sh,
    output logic            reinit,
    output logic            uev,
    output logic            flag_set,
    output logic            opm_stop
);
    logic [CW-1:0]   arr_sh;
    logic [CW-1:0]   arr_eff;
    logic [REPW-1:0] rep_cnt;
    logic            wrap, ovf_evt;

    assign reinit   = sw_upd || ext_upd;
    assign arr_eff  = ctrl.buffered ? arr_sh : arr_pre;
    assign wrap     = tick && (cnt == arr_eff);
    assign ovf_evt  = wrap && (rep_cnt == '0);
    assign uev      = !ctrl.hold && (reinit || ovf_evt);
    assign flag_set = uev && (ovf_evt || !ctrl.filter);
    assign opm_stop = uev && ctrl.oneshot;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            arr_sh  <= '1;
            psc_sh  <= '0;
            rep_cnt <= '0;
        end else begin
            if (reinit)
                cnt <= '0;
            else if (tick)
                cnt <= wrap ? '0 : cnt + 1'b1;

            if (uev) begin
                rep_cnt <= rep_pre;
                arr_sh  <= arr_pre;
                psc_sh  <= psc_pre;
            end else if (wrap && rep_cnt != '0) begin
                rep_cnt <= rep_cnt - 1'b1;
            end
        end
    end

    // R1: a stopped counter keeps its value
    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        !ctrl.run && !reinit |=> $stable(cnt));
    // R3: reaching the limit on a step returns the count to zero
    a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        tick && (cnt == arr_eff) && !reinit |=> cnt == '0);
    // R5: working copies are untouched while updates are held
    a_r5_hold_shadow: assert property (@(posedge clk) disable iff (rst)
        ctrl.hold |=> $stable(arr_sh) && $stable(psc_sh));
    // R9: a restart request clears the count
    a_r9_restart: assert property (@(posedge clk) disable iff (rst)
        reinit |=> cnt == '0);
endmodule

// File: rtl/tbase_timer.sv
module tbase_timer
    import tbase_pkg::*;
#(
    parameter int CW   = CNT_W,
    parameter int PW   = PSC_W,
    parameter int REPW = REP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          ext_update,
    output logic          update_pulse,
    output logic          irq
);
    ctrl_t            ctrl;
    logic             uie, flag, sw_upd, opm_stop, flag_set;
    logic             tick, reinit, uev;
    logic [PW-1:0]    psc_pre, psc_sh;
    logic [CW-1:0]    arr_pre, cnt;
    logic [REPW-1:0]  rep_pre;

    tbase_regs #(.CW(CW), .PW(PW), .REPW(REPW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .opm_stop(opm_stop), .flag_set(flag_set), .ctrl(ctrl), .uie(uie),
        .flag(flag), .sw_upd(sw_upd), .psc_pre(psc_pre), .arr_pre(arr_pre),
        .rep_pre(rep_pre)
    );

    tbase_prescale #(.PW(PW)) u_psc (
        .clk(clk), .rst(rst), .run(ctrl.run), .clear(reinit),
        .limit(psc_sh), .tick(tick)
    );

    tbase_count #(.CW(CW), .PW(PW), .REPW(REPW)) u_count (
        .clk(clk), .rst(rst), .tick(tick), .ctrl(ctrl), .sw_upd(sw_upd),
        .ext_upd(ext_update), .psc_pre(psc_pre), .arr_pre(arr_pre),
        .rep_pre(rep_pre), .cnt(cnt), .psc_sh(psc_sh), .reinit(reinit),
        .uev(uev), .flag_set(flag_set), .opm_stop(opm_stop)
    );

    always_ff @(posedge clk) begin
        if (rst) update_pulse <= 1'b0;
        else     update_pulse <= uev;
    end

    assign irq = flag && uie;

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL: rd_data = pack_ctrl(ctrl);
            A_IEN:  rd_data[0] = uie;
            A_STAT: rd_data[0] = flag;
            A_EVT:  rd_data = '0;
            A_CNT: begin
                rd_data[CW-1:0] = cnt;
                rd_data[DW-1]   = ctrl.mirror && flag;
            end
            A_PSC:  rd_data[PW-1:0]   = psc_pre;
            A_ARR:  rd_data[CW-1:0]   = arr_pre;
            A_REP:  rd_data[REPW-1:0] = rep_pre;
            default: rd_data = '0;
        endcase
    end

    // R11: the interrupt request never rises without a pending flag
    a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag);
    // R9: every update event is followed by a pulse
    a_r9_pulse: assert property (@(posedge clk) disable iff (rst)
        uev |=> update_pulse);
endmodule

// File: tb/tbase_timer_test.sv
module tbase_timer_test;
    import tbase_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        ext_update = 1'b0;
    logic        update_pulse;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    tbase_timer uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ext_update(ext_update),
        .update_pulse(update_pulse), .irq(irq)
    );

    typedef struct packed {
        logic [15:0] p;
        logic [15:0] a;
        logic [7:0]  r;
        logic [15:0] c;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{16'd0, 16'd9, 8'd0, 16'd5},
        '{16'd0, 16'd4, 8'd0, 16'd7},
        '{16'd2, 16'd3, 8'd0, 16'd10},
        '{16'd1, 16'd2, 8'd1, 16'd12},
        '{16'd1, 16'd2, 8'd1, 16'd9},
        '{16'd0, 16'd0, 8'd3, 16'd6},
        '{16'd3, 16'd5, 8'd2, 16'd40}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic run_for(input logic [31:0] ctrl_on, input int c);
        wr(3'(A_CTRL), ctrl_on);
        repeat (c) @(posedge clk);
        wr(3'(A_CTRL), ctrl_on & ~32'h1);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(3'(A_CNT), v);  chk("R1 reset count", v, 32'h0);
        rd(3'(A_STAT), v); chk("R1 reset flag", v, 32'h0);
        rd(3'(A_CTRL), v); chk("R1 reset control", v, 32'h0);
        rd(3'(A_ARR), v);  chk("R1 reset limit", v, 32'hFFFF);
        chk("R11 reset irq", {31'b0, irq}, 32'h0);

        // R2 R3 R4: vector table
        for (int i = 0; i < 7; i++) begin
            int k, ticks, ecnt, ovf;
            wr(3'(A_CTRL), 32'h0);
            wr(3'(A_PSC), 32'(VECS[i].p));
            wr(3'(A_ARR), 32'(VECS[i].a));
            wr(3'(A_REP), 32'(VECS[i].r));
            wr(3'(A_EVT), 32'h1);
            wr(3'(A_STAT), 32'h0);
            run_for(32'h1, int'(VECS[i].c));
            k     = int'(VECS[i].c) + 1;
            ticks = k / (int'(VECS[i].p) + 1);
            ecnt  = ticks % (int'(VECS[i].a) + 1);
            ovf   = ticks / (int'(VECS[i].a) + 1);
            rd(3'(A_CNT), v);
            chk($sformatf("R2 R3 vector %0d count", i), v, 32'(ecnt));
            rd(3'(A_STAT), v);
            chk($sformatf("R4 vector %0d flag", i), v,
                (ovf >= int'(VECS[i].r) + 1) ? 32'h1 : 32'h0);
        end

        // R1: stopped counter holds
        rd(3'(A_CNT), v);
        repeat (5) @(negedge clk);
        begin
            logic [31:0] v2;
            rd(3'(A_CNT), v2);
            chk("R1 stopped count holds", v2, v);
        end

        // R5: hold blocks the divider load and the flag
        wr(3'(A_CTRL), 32'h0);
        wr(3'(A_PSC), 32'h0);
        wr(3'(A_ARR), 32'h3);
        wr(3'(A_REP), 32'h0);
        wr(3'(A_EVT), 32'h1);
        wr(3'(A_STAT), 32'h0);
        wr(3'(A_CTRL), 32'h2);
        wr(3'(A_PSC), 32'h1);
        wr(3'(A_EVT), 32'h1);
        rd(3'(A_CNT), v);  chk("R5 restart still clears count", v, 32'h0);
        run_for(32'h3, 5);
        rd(3'(A_CNT), v);  chk("R5 old divider kept, count wraps", v, 32'h2);
        rd(3'(A_STAT), v); chk("R5 no flag while held", v, 32'h0);

        // R6: filter blocks strobe flag, overflow still flags
        wr(3'(A_CTRL), 32'h4);
        wr(3'(A_PSC), 32'h0);
        wr(3'(A_ARR), 32'h2);
        wr(3'(A_EVT), 32'h1);
        rd(3'(A_STAT), v); chk("R6 strobe filtered", v, 32'h0);
        run_for(32'h5, 3);
        rd(3'(A_CNT), v);  chk("R6 count after overflow", v, 32'h1);
        rd(3'(A_STAT), v); chk("R6 overflow flags", v, 32'h1);

        // R13: external update with filter off
        wr(3'(A_CTRL), 32'h0);
        wr(3'(A_STAT), 32'h0);
        @(negedge clk); ext_update = 1'b1;
        @(negedge clk); ext_update = 1'b0;
        chk("R13 update pulse", {31'b0, update_pulse}, 32'h1);
        rd(3'(A_STAT), v); chk("R13 external flag", v, 32'h1);
        rd(3'(A_CNT), v);  chk("R13 external clears count", v, 32'h0);

        // R7: one-shot
        wr(3'(A_ARR), 32'h3);
        wr(3'(A_EVT), 32'h1);
        wr(3'(A_STAT), 32'h0);
        wr(3'(A_CTRL), 32'h9);
        repeat (10) @(negedge clk);
        rd(3'(A_CTRL), v); chk("R7 run bit cleared", v, 32'h8);
        rd(3'(A_CNT), v);  chk("R7 count parked at 0", v, 32'h0);
        rd(3'(A_STAT), v); chk("R7 flag set", v, 32'h1);

        // R8: buffered limit
        wr(3'(A_CTRL), 32'h80);
        wr(3'(A_ARR), 32'h9);
        wr(3'(A_EVT), 32'h1);
        wr(3'(A_STAT), 32'h0);
        wr(3'(A_ARR), 32'h3);
        run_for(32'h81, 6);
        rd(3'(A_CNT), v);  chk("R8 buffered limit not yet used", v, 32'h7);
        run_for(32'h81, 7);
        rd(3'(A_CNT), v);  chk("R8 new limit after update", v, 32'h1);

        // R8: unbuffered limit
        wr(3'(A_CTRL), 32'h0);
        wr(3'(A_ARR), 32'h9);
        wr(3'(A_EVT), 32'h1);
        wr(3'(A_STAT), 32'h0);
        run_for(32'h1, 1);
        rd(3'(A_CNT), v);  chk("R8 count before change", v, 32'h2);
        wr(3'(A_ARR), 32'h4);
        run_for(32'h1, 3);
        rd(3'(A_CNT), v);  chk("R8 immediate limit", v, 32'h1);
        rd(3'(A_STAT), v); chk("R8 flag at new limit", v, 32'h1);

        // R12: mirror
        wr(3'(A_CTRL), 32'h800);
        rd(3'(A_CNT), v);  chk("R12 mirror bit set", v, 32'h8000_0001);
        wr(3'(A_CTRL), 32'h0);
        rd(3'(A_CNT), v);  chk("R12 mirror off", v, 32'h1);

        // R10: clear semantics
        wr(3'(A_STAT), 32'h1);
        rd(3'(A_STAT), v); chk("R10 write 1 keeps flag", v, 32'h1);

        // R11: interrupt gating
        wr(3'(A_IEN), 32'h1);
        chk("R11 irq with flag", {31'b0, irq}, 32'h1);
        wr(3'(A_STAT), 32'h0);
        rd(3'(A_STAT), v); chk("R10 write 0 clears flag", v, 32'h0);
        chk("R11 irq drops with flag", {31'b0, irq}, 32'h0);

        // R9: software strobe mid-count
        run_for(32'h1, 2);
        wr(3'(A_EVT), 32'h1);
        chk("R9 update pulse", {31'b0, update_pulse}, 32'h1);
        rd(3'(A_CNT), v);  chk("R9 strobe clears count", v, 32'h0);
        rd(3'(A_STAT), v); chk("R9 strobe sets flag", v, 32'h1);
        chk("R11 irq after strobe", {31'b0, irq}, 32'h1);
        wr(3'(A_IEN), 32'h0);
        chk("R11 irq masked", {31'b0, irq}, 32'h0);

        done = 1'b1;
        summary();
    end
endmodule